// File: doc/BRIEF.md
# Blocking write-through data cache initiator

This block places a direct-mapped data cache between a single-issue 32-bit processor and a VCI initiator port. Loads that hit are answered from the local arrays. A load miss fetches one whole line from memory: the request is a single command flit, and the response returns the line as a train of flits. Every store goes to memory as a one-flit VCI write. If the addressed line is present, the cached word is also updated. A store to a line that is not present leaves the cache unchanged.

The block is blocking. It keeps at most one VCI transaction open, and it does not issue another command until the final flit of the previous response has been consumed. The processor holds its request stable until `cpu_done` pulses. `cpu_done` carries the load data and an error flag. `cpu_stall` tells the processor when the request has to wait for memory.

Address split, with the defaults `LINE_WORDS=4` and `SETS=16`:
- bits [3:2] select the word in the line,
- bits [7:4] select the set,
- bits [31:8] form the tag.

In general, the word offset takes log2(`LINE_WORDS`) bits above the byte bits, the set index takes the next log2(`SETS`) bits, and the tag takes the rest.

Top module: `wt_cache_initiator`

## Requirements
- R1: A load that hits raises `cpu_done` on the first clock edge after the request is accepted, with the cached word on `cpu_rdata`. `cpu_stall` stays low and no VCI command is issued.
- R2: A load miss raises `cpu_stall` in the acceptance cycle and keeps it high until `cpu_done`. It issues exactly one command flit with the following fields:
  - `vci_cmd` = 2'b01 (read),
  - the line-aligned address,
  - `vci_plen` = `LINE_WORDS`*4 bytes,
  - `vci_be` = 4'hF,
  - `vci_eop` = 1.
- R3: Response flits of a fill are written into the line in order. The word named by the request address is returned. The line is then valid, so a later load to it hits.
- R4: Every store raises `cpu_stall` and issues exactly one write flit with the following fields:
  - `vci_cmd` = 2'b10 (write),
  - the full request address, data and byte enables,
  - `vci_plen` = 4,
  - `vci_eop` = 1.
  `cpu_done` follows the single response flit.
- R5: A store that hits updates only the bytes of the cached word selected by `cpu_be`. A store that misses allocates nothing, so a later load of that address misses.
- R6: `vci_cmdval` is never high between a command handshake and the end-of-packet flit of its response.
- R7: `vci_trdid` and `vci_pktid` are always zero.
- R8: If `vci_rerror` is set on any response flit, the processor sees `cpu_err`=1 with `cpu_done`. A line filled with an error is left invalid.
- R9: A fill response is treated as an error, with the line left invalid, in either of these cases:
  - its end-of-packet flag is not on flit number `LINE_WORDS`,
  - it carries a different number of flits.
- R10: During and right after reset, all of the following are low: `cpu_stall`, `cpu_done`, `vci_cmdval` and `vci_rspack`. Every line is invalid.
- R11: While `vci_cmdval` is high and not acknowledged, all command fields hold steady.
- R12: `vci_rspack` is high throughout the response phase of every transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_stall | output | 1 | Request waits for memory |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| cpu_err | output | 1 | Bus error, valid with `cpu_done` |
| vci_cmdval | output | 1 | Command flit valid |
| vci_cmdack | input | 1 | Command flit accepted |
| vci_address | output | 32 | Command address |
| vci_cmd | output | 2 | 01 read, 10 write |
| vci_be | output | 4 | Command byte enables |
| vci_wdata | output | 32 | Command write data |
| vci_plen | output | PLEN_W | Packet length in bytes |
| vci_eop | output | 1 | Last command flit |
| vci_trdid | output | ID_W | Thread id, always zero |
| vci_pktid | output | ID_W | Packet id, always zero |
| vci_rspval | input | 1 | Response flit valid |
| vci_rspack | output | 1 | Response flit accepted |
| vci_rdata | input | 32 | Response data |
| vci_reop | input | 1 | Last response flit |
| vci_rerror | input | 1 | Response error |

## Verification
Each result falls due at a fixed time, and the bench samples at that time:

| Result | When it is due | When the bench samples it |
|---|---|---|
| `cpu_stall` | Combinational: valid in the same cycle the request is presented | At a short delay after driving the request |
| Load hit completion | Exactly one edge after acceptance | On the first falling edge after acceptance, and nowhere else |
| Miss or store completion | One edge after the final response flit, which the bench's memory model produces with random delays | The bench waits for `cpu_done` and requires `cpu_stall` high on every falling edge before it |
| Command fields | Held while the command waits | Captured when the command first appears and compared again at the handshake |

The bench predicts hit or miss, data and error from its own model of valid bits, tags and line copies. It checks response acknowledgement on every flit it presents.

// File: rtl/wt_cache_initiator.sv
module wt_cache_initiator #(
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int ID_W       = 4,
  parameter int PLEN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_be,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_err,
  output logic              vci_cmdval,
  input  logic              vci_cmdack,
  output logic [31:0]       vci_address,
  output logic [1:0]        vci_cmd,
  output logic [3:0]        vci_be,
  output logic [31:0]       vci_wdata,
  output logic [PLEN_W-1:0] vci_plen,
  output logic              vci_eop,
  output logic [ID_W-1:0]   vci_trdid,
  output logic [ID_W-1:0]   vci_pktid,
  input  logic              vci_rspval,
  output logic              vci_rspack,
  input  logic [31:0]       vci_rdata,
  input  logic              vci_reop,
  input  logic              vci_rerror
);

  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int IDX_LSB = OFF_W + 2;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int TAG_W   = 32 - TAG_LSB;
  localparam logic [OFF_W-1:0]  LAST    = OFF_W'(LINE_WORDS - 1);
  localparam logic [PLEN_W-1:0] RD_PLEN = PLEN_W'(LINE_WORDS * 4);
  localparam logic [PLEN_W-1:0] WR_PLEN = PLEN_W'(4);

  typedef enum logic [2:0] {S_IDLE, S_RCMD, S_RRSP, S_WCMD, S_WRSP, S_DONE} st_e;

  st_e                 state;
  logic [TAG_W-1:0]    tag_q  [SETS];
  logic [31:0]         data_q [SETS*LINE_WORDS];
  logic [SETS-1:0]     valid_q;
  logic [31:0]         addr_q, wdata_q;
  logic [3:0]          be_q;
  logic [OFF_W-1:0]    cnt_q;
  logic                ferr_q;

  wire [IDX_W-1:0] c_idx = cpu_addr[TAG_LSB-1:IDX_LSB];
  wire [OFF_W-1:0] c_off = cpu_addr[IDX_LSB-1:2];
  wire [TAG_W-1:0] c_tag = cpu_addr[31:TAG_LSB];
  wire [IDX_W-1:0] q_idx = addr_q[TAG_LSB-1:IDX_LSB];
  wire [OFF_W-1:0] q_off = addr_q[IDX_LSB-1:2];

  wire hit      = valid_q[c_idx] && (tag_q[c_idx] == c_tag);
  wire accept   = (state == S_IDLE) && cpu_req;
  wire busy     = (state == S_RCMD) || (state == S_RRSP) || (state == S_WCMD) || (state == S_WRSP);
  wire flit_bad = vci_rerror || (vci_reop != (cnt_q == LAST));
  wire fill_err = ferr_q || flit_bad;

  assign cpu_stall   = busy || (accept && (cpu_we || !hit));
  assign cpu_done    = (state == S_DONE);
  assign vci_cmdval  = (state == S_RCMD) || (state == S_WCMD);
  assign vci_cmd     = (state == S_WCMD) ? 2'b10 : 2'b01;
  assign vci_address = (state == S_WCMD) ? addr_q : {addr_q[31:IDX_LSB], {IDX_LSB{1'b0}}};
  assign vci_be      = (state == S_WCMD) ? be_q : 4'hF;
  assign vci_wdata   = wdata_q;
  assign vci_plen    = (state == S_WCMD) ? WR_PLEN : RD_PLEN;
  assign vci_eop     = 1'b1;
  assign vci_trdid   = '0;
  assign vci_pktid   = '0;
  assign vci_rspack  = (state == S_RRSP) || (state == S_WRSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      valid_q   <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      cnt_q     <= '0;
      ferr_q    <= 1'b0;
      cpu_rdata <= '0;
      cpu_err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req) begin
          addr_q  <= cpu_addr;
          wdata_q <= cpu_wdata;
          be_q    <= cpu_be;
          cpu_err <= 1'b0;
          if (cpu_we) state <= S_WCMD;
          else if (hit) begin
            cpu_rdata <= data_q[{c_idx, c_off}];
            state     <= S_DONE;
          end else begin
            valid_q[c_idx] <= 1'b0;
            cnt_q          <= '0;
            ferr_q         <= 1'b0;
            state          <= S_RCMD;
          end
        end
        S_RCMD: if (vci_cmdack) state <= S_RRSP;
        S_WCMD: if (vci_cmdack) state <= S_WRSP;
        S_RRSP: if (vci_rspval) begin
          if (cnt_q == q_off) cpu_rdata <= vci_rdata;
          if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
          ferr_q <= fill_err;
          if (vci_reop) begin
            valid_q[q_idx] <= !fill_err;
            cpu_err        <= fill_err;
            state          <= S_DONE;
          end
        end
        S_WRSP: if (vci_rspval) begin
          cpu_err <= vci_rerror;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !cpu_we && !hit) tag_q[c_idx] <= c_tag;
    if (accept && cpu_we && hit)
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) data_q[{c_idx, c_off}][8*b +: 8] <= cpu_wdata[8*b +: 8];
    if (state == S_RRSP && vci_rspval) data_q[{q_idx, cnt_q}] <= vci_rdata;
  end

endmodule

// File: rtl/wt_cache_initiator_chk.sv
module wt_cache_initiator_chk #(
  parameter int LINE_WORDS = 4,
  parameter int ID_W       = 4,
  parameter int PLEN_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              vci_cmdval,
  input logic              vci_cmdack,
  input logic [31:0]       vci_address,
  input logic [1:0]        vci_cmd,
  input logic [3:0]        vci_be,
  input logic [31:0]       vci_wdata,
  input logic [PLEN_W-1:0] vci_plen,
  input logic              vci_eop,
  input logic [ID_W-1:0]   vci_trdid,
  input logic [ID_W-1:0]   vci_pktid,
  input logic              vci_rspval,
  input logic              vci_rspack,
  input logic              vci_reop
);
  localparam int OFF_W = $clog2(LINE_WORDS) + 2;

  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (vci_cmdval && vci_cmdack) pend <= 1'b1;
    else if (vci_rspval && vci_rspack && vci_reop) pend <= 1'b0;
  end

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !vci_cmdval);
  a_r12_rspack_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> vci_rspack);
  a_r7_ids_zero: assert property (@(posedge clk) disable iff (!rst_n)
    vci_cmdval |-> (vci_trdid == '0 && vci_pktid == '0));
  a_r2_read_flit: assert property (@(posedge clk) disable iff (!rst_n)
    (vci_cmdval && vci_cmd == 2'b01) |->
      (vci_eop && vci_be == 4'hF && vci_plen == PLEN_W'(LINE_WORDS*4) && vci_address[OFF_W-1:0] == '0));
  a_r4_write_flit: assert property (@(posedge clk) disable iff (!rst_n)
    (vci_cmdval && vci_cmd == 2'b10) |-> (vci_eop && vci_plen == PLEN_W'(4)));
  a_r11_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (vci_cmdval && !vci_cmdack) |=>
      (vci_cmdval && $stable(vci_address) && $stable(vci_cmd) && $stable(vci_be) && $stable(vci_wdata)));
  a_r1_done_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_stall);
endmodule

bind wt_cache_initiator wt_cache_initiator_chk #(
  .LINE_WORDS(LINE_WORDS), .ID_W(ID_W), .PLEN_W(PLEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
  .vci_cmdval(vci_cmdval), .vci_cmdack(vci_cmdack), .vci_address(vci_address),
  .vci_cmd(vci_cmd), .vci_be(vci_be), .vci_wdata(vci_wdata), .vci_plen(vci_plen),
  .vci_eop(vci_eop), .vci_trdid(vci_trdid), .vci_pktid(vci_pktid),
  .vci_rspval(vci_rspval), .vci_rspack(vci_rspack), .vci_reop(vci_reop)
);

// File: tb/wt_cache_initiator_tb.sv
module wt_cache_initiator_tb;
  localparam int LINE = 4, SETS = 16, ID_W = 4, PLEN_W = 8;
  localparam int OFF_W = $clog2(LINE), IDX_W = $clog2(SETS);
  localparam int TAG_LSB = 2 + OFF_W + IDX_W;
  localparam int MEMW = 1024;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0] cpu_be = 0;
  logic cpu_stall, cpu_done, cpu_err;
  logic [31:0] cpu_rdata;
  logic vci_cmdval, vci_cmdack, vci_eop, vci_rspval, vci_rspack, vci_reop, vci_rerror;
  logic [31:0] vci_address, vci_wdata, vci_rdata;
  logic [1:0] vci_cmd;
  logic [3:0] vci_be;
  logic [PLEN_W-1:0] vci_plen;
  logic [ID_W-1:0] vci_trdid, vci_pktid;

  wt_cache_initiator #(.LINE_WORDS(LINE), .SETS(SETS), .ID_W(ID_W), .PLEN_W(PLEN_W)) u_dut (.*);

  always #5ns clk = ~clk;

  int n_chk = 0, n_fail = 0, n_cmd = 0, mon_viol = 0;
  logic [31:0] mem [MEMW];
  bit rv [SETS];
  logic [31:0] rt [SETS];
  logic [31:0] rd [SETS*LINE];
  bit inj_err = 0, inj_short = 0, inj_long = 0, tgt_busy = 0;
  logic [31:0] t_addr, t_wdata;
  logic [1:0] t_cmd;
  logic [3:0] t_be;
  logic [PLEN_W-1:0] t_plen;
  logic t_eop, t_ids0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int f_idx(logic [31:0] a); return int'((a >> (2 + OFF_W)) % SETS); endfunction
  function automatic int f_off(logic [31:0] a); return int'((a >> 2) % LINE); endfunction
  function automatic logic [31:0] f_tag(logic [31:0] a); return a >> TAG_LSB; endfunction
  function automatic int f_mi(logic [31:0] a); return int'((a >> 2) % MEMW); endfunction
  function automatic logic [31:0] f_merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  // memory target
  initial begin
    logic [31:0] s_addr, s_wdata;
    logic [1:0] s_cmd;
    logic [3:0] s_be;
    int nfl;
    vci_cmdack = 0; vci_rspval = 0; vci_rdata = 0; vci_reop = 0; vci_rerror = 0;
    forever begin
      @(negedge clk);
      if (vci_cmdval === 1'b1) begin
        s_addr = vci_address; s_cmd = vci_cmd; s_be = vci_be; s_wdata = vci_wdata;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        check(vci_address == s_addr && vci_cmd == s_cmd && vci_be == s_be && vci_wdata == s_wdata,
              "R11", "command fields held", vci_address, s_addr);
        t_addr = vci_address; t_cmd = vci_cmd; t_be = vci_be; t_wdata = vci_wdata;
        t_plen = vci_plen; t_eop = vci_eop; t_ids0 = (vci_trdid == 0 && vci_pktid == 0);
        n_cmd++;
        vci_cmdack = 1; @(negedge clk); vci_cmdack = 0; tgt_busy = 1;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (t_cmd == 2'b01) begin
          nfl = LINE + (inj_long ? 1 : 0) - (inj_short ? 1 : 0);
          for (int w = 0; w < nfl; w++) begin
            vci_rspval = 1; vci_reop = (w == nfl - 1); vci_rerror = inj_err && (w == 1);
            vci_rdata = mem[f_mi(t_addr + 32'(4 * (w % LINE)))];
            check(vci_rspack, "R12", "rspack on fill flit", {31'd0, vci_rspack}, 1);
            @(negedge clk);
          end
        end else begin
          if (!inj_err) mem[f_mi(t_addr)] = f_merge(mem[f_mi(t_addr)], t_wdata, t_be);
          vci_rspval = 1; vci_reop = 1; vci_rerror = inj_err;
          check(vci_rspack, "R12", "rspack on write response", {31'd0, vci_rspack}, 1);
          @(negedge clk);
        end
        vci_rspval = 0; vci_reop = 0; vci_rerror = 0; tgt_busy = 0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (tgt_busy && vci_cmdval) begin
      mon_viol++;
      $display("FAIL R6 command during open transaction: actual 1 expected 0");
    end
  end

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be);
    int idx = f_idx(a), off = f_off(a), cyc = 0, cmd0 = n_cmd;
    bit hit = rv[idx] && rt[idx] == f_tag(a), gap = 0, exp_err;
    logic [31:0] exp_d = mem[f_mi(a)];
    exp_err = we ? inj_err : (!hit && (inj_err || inj_short || inj_long));
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    #1ns;
    check(cpu_stall == (we || !hit), we ? "R4" : (hit ? "R1" : "R2"), "stall at acceptance",
          {31'd0, cpu_stall}, {31'd0, we || !hit});
    do begin
      @(negedge clk); cyc++;
      if (!cpu_done && !cpu_stall) gap = 1;
    end while (!cpu_done && cyc < 300);
    cpu_req = 0;
    check(cpu_done, "R2", "request completes", {31'd0, cpu_done}, 1);
    check(cpu_err == exp_err, "R8", "error flag", {31'd0, cpu_err}, {31'd0, exp_err});
    if (we) begin
      check(n_cmd == cmd0 + 1 && t_cmd == 2'b10 && t_addr == a && t_wdata == wd && t_be == be
            && t_plen == 4 && t_eop, "R4", "write flit", t_addr, a);
      check(t_ids0, "R7", "ids zero on write", {31'd0, t_ids0}, 1);
      if (hit) rd[idx*LINE+off] = f_merge(rd[idx*LINE+off], wd, be);
    end else if (hit) begin
      check(cyc == 1, "R1", "hit latency", cyc, 1);
      check(n_cmd == cmd0, "R1", "no command on hit", n_cmd, cmd0);
      check(cpu_rdata == rd[idx*LINE+off], "R1", "hit data", cpu_rdata, rd[idx*LINE+off]);
    end else begin
      check(!gap, "R2", "stall held through miss", {31'd0, gap}, 0);
      check(n_cmd == cmd0 + 1 && t_cmd == 2'b01 && t_be == 4'hF && t_eop
            && t_plen == PLEN_W'(LINE*4) && t_addr == (a & ~32'(LINE*4-1)),
            "R2", "read flit", t_addr, a & ~32'(LINE*4-1));
      check(t_ids0, "R7", "ids zero on read", {31'd0, t_ids0}, 1);
      rv[idx] = !exp_err;
      if (!exp_err) begin
        check(cpu_rdata == exp_d, "R3", "fill data", cpu_rdata, exp_d);
        rt[idx] = f_tag(a);
        for (int w = 0; w < LINE; w++) rd[idx*LINE+w] = mem[f_mi((a & ~32'(LINE*4-1)) + 32'(4*w))];
      end
    end
  endtask

  task automatic expect_miss(input logic [31:0] a, input string rq);
    int c0 = n_cmd;
    do_op(0, a, 0, 0);
    check(n_cmd == c0 + 1, rq, "later load misses", n_cmd, c0 + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, v;
    int c0;
    void'($urandom(32'd2024));
    for (int i = 0; i < MEMW; i++) mem[i] = i * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
    for (int s = 0; s < SETS; s++) rv[s] = 0;
    repeat (3) @(negedge clk);
    check(!cpu_stall && !cpu_done && !vci_cmdval && !vci_rspack, "R10", "outputs in reset",
          {28'd0, cpu_stall, cpu_done, vci_cmdval, vci_rspack}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!cpu_stall && !cpu_done && !vci_cmdval && !vci_rspack, "R10", "outputs after reset",
          {28'd0, cpu_stall, cpu_done, vci_cmdval, vci_rspack}, 0);
    expect_miss(32'h0000_0128, "R10");
    c0 = n_cmd;
    do_op(0, 32'h0000_0124, 0, 0);
    check(n_cmd == c0, "R3", "filled line hits", n_cmd, c0);
    // write hit, partial bytes
    a = 32'h0000_012C; v = rd[f_idx(a)*LINE + f_off(a)];
    do_op(1, a, 32'hA1B2_C3D4, 4'b0101);
    do_op(0, a, 0, 0);
    check(cpu_rdata == f_merge(v, 32'hA1B2_C3D4, 4'b0101), "R5", "byte-merged hit",
          cpu_rdata, f_merge(v, 32'hA1B2_C3D4, 4'b0101));
    // write miss, no allocate
    do_op(1, 32'h0000_0340, 32'h1234_5678, 4'hF);
    expect_miss(32'h0000_0340, "R5");
    check(cpu_rdata == 32'h1234_5678, "R5", "store reached memory", cpu_rdata, 32'h1234_5678);
    // error on fill
    inj_err = 1; do_op(0, 32'h0000_0580, 0, 0); inj_err = 0;
    expect_miss(32'h0000_0584, "R8");
    // write error
    inj_err = 1; do_op(1, 32'h0000_0600, 32'hDEAD_BEEF, 4'hF); inj_err = 0;
    // short and long fills
    inj_short = 1; do_op(0, 32'h0000_0790, 0, 0); inj_short = 0;
    check(cpu_err, "R9", "short fill flagged", {31'd0, cpu_err}, 1);
    expect_miss(32'h0000_0790, "R9");
    inj_long = 1; do_op(0, 32'h0000_07A0, 0, 0); inj_long = 0;
    check(cpu_err, "R9", "long fill flagged", {31'd0, cpu_err}, 1);
    expect_miss(32'h0000_07A0, "R9");
    // random traffic
    for (int i = 0; i < 500; i++) begin
      a = $urandom & 32'h0000_03FC;
      if ($urandom_range(0, 9) < 6) do_op(0, a, 0, 0);
      else do_op(1, a, $urandom, 4'($urandom_range(1, 15)));
    end
    check(mon_viol == 0, "R6", "no overlapping transactions", mon_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule